// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of peripheral sources and decides which one the CPU should service next. A request held high on a source input for one clock sets that source's pending flag. The flag stays set until software clears it. Each source also has an enable bit and a 3-bit priority. Every cycle the block picks the pending, enabled source with the highest priority that is strictly above the CPU's current priority. It publishes that source's vector number and level in a read-only status word and drives an interrupt line to the CPU.

The CPU sees a 4-bit current priority level. On an acknowledge pulse the block saves the current level on a small internal stack and raises the level to the one being serviced. On a return pulse it restores the saved level. A global nesting-disable bit makes every acknowledged interrupt raise the level to the top user level, so nothing can preempt it. Software reaches all state through a 16-bit register bus with a 6-bit word address. Writes are single-cycle and reads are combinational.

Top module: `prio_vec_intc`

## Requirements
- R1: When `irq_src[i]` is high at a clock edge, flag bit i reads 1 from the next cycle on. It stays 1 until software writes a 0 to it.
- R2: A write to flag word 0x08+k loads bit b into the flag of source 16k+b, so writing 1 sets a flag and writing 0 clears it. If a hardware request arrives in the same cycle as a clearing write, the flag ends at 1.
- R3: Enable word 0x10+k uses the same bit layout as the flag words. A source whose enable bit is 0 never wins arbitration, yet its flag still latches.
- R4: Priority word 0x20+k holds source 4k+j in bits 3j+2..3j, and bits 15..12 always read 0. A priority of 0 means the source never requests.
- R5: Among the qualifying sources, the one with the highest priority wins. On equal priority, the lowest source index wins.
- R6: A source qualifies only if its flag is set, its enable is set, and its priority is strictly greater than the current CPU level. With no qualifying source, the status reads vector 0 and level 0, and `irq_out` is low.
- R7: The status word at 0x02 holds the vector (source index + 8) in bits 6..0 and the level in bits 11..8; all other bits are 0. It reflects state one clock after that state changes. The outputs `irq_out`, `irq_vec` and `irq_lvl` mirror it. Writes to 0x02 have no effect.
- R8: The CPU level word at 0x01 holds the current level in bits 3..0. Software writes change only bits 2..0. Bit 3 cannot be written by software and reads 0 after reset.
- R9: When `cpu_ack` is high, `irq_out` is high and `cpu_ret` is low, the block pushes the current level and loads the status level into the CPU level. If the nesting-disable bit (word 0x00, bit 0) is set, it loads 7 instead. An acknowledge while `irq_out` is low is ignored.
- R10: `cpu_ret` pops the most recently saved level back into the CPU level; the stack holds 8 entries. A return with an empty stack leaves the level unchanged.
- R11: After reset, every register reads 0 and `irq_out` is low. Addresses with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| irq_src | input | NUM_SRC | Per-source request pulses from peripherals |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from `bus_addr` |
| cpu_ack | input | 1 | CPU accepts the presented interrupt |
| cpu_ret | input | 1 | CPU returns from the current interrupt |
| irq_out | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 7 | Vector number of the presented request |
| irq_lvl | output | 4 | Priority level of the presented request |

## Verification
A fault in a flag, enable or priority register shows up at the status word one clock later, as a wrong vector, a wrong level, or a request that should not be there. Sweeping many source patterns against every CPU level therefore exposes arbitration and packing errors right away. A corrupted level stack is only visible when a return pulse fires. The bench then reads the CPU level word after each acknowledge and each return, and checks the re-presented request one clock after that.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W         = 16;
  localparam int ADDR_W         = 6;
  localparam int LVL_W          = 4;
  localparam int PRIO_W         = 3;
  localparam int VEC_W          = 7;
  localparam int VEC_BASE       = 8;
  localparam int FIELDS_PER_REG = 4;

  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_LEVEL  = 1;
  localparam int A_STATUS = 2;
  localparam int A_FLAG   = 8;
  localparam int A_ENABLE = 16;
  localparam int A_PRIO   = 32;

  localparam logic [LVL_W-1:0] TOP_USER_LVL = 4'd7;

  typedef struct packed {
    logic             valid;
    logic [VEC_W-1:0] vec;
    logic [LVL_W-1:0] lvl;
  } grant_t;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        hw_req,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [NUM_SRC-1:0]        flag,
  output logic [NUM_SRC-1:0]        enable,
  output logic [NUM_SRC*PRIO_W-1:0] prio
);
  int addr_i;
  assign addr_i = int'(bus_addr);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    localparam int WORD = gi / DATA_W;
    localparam int BITP = gi % DATA_W;
    localparam int PREG = gi / FIELDS_PER_REG;
    localparam int PLSB = (gi % FIELDS_PER_REG) * PRIO_W;

    logic              sel_f, sel_e, sel_p;
    logic              f_q, f_d, e_q, e_d;
    logic [PRIO_W-1:0] p_q, p_d;

    assign sel_f = bus_wr && (addr_i == A_FLAG + WORD);
    assign sel_e = bus_wr && (addr_i == A_ENABLE + WORD);
    assign sel_p = bus_wr && (addr_i == A_PRIO + PREG);

    // hardware set overrides a software clear in the same cycle
    always_comb begin
      f_d = f_q;
      if (sel_f)      f_d = bus_wdata[BITP];
      if (hw_req[gi]) f_d = 1'b1;
    end

    always_comb begin
      e_d = e_q;
      if (sel_e) e_d = bus_wdata[BITP];
    end

    always_comb begin
      p_d = p_q;
      if (sel_p) p_d = bus_wdata[PLSB +: PRIO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        e_q <= 1'b0;
        p_q <= '0;
      end else begin
        f_q <= f_d;
        e_q <= e_d;
        p_q <= p_d;
      end
    end

    assign flag[gi]                 = f_q;
    assign enable[gi]               = e_q;
    assign prio[gi*PRIO_W +: PRIO_W] = p_q;

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hw_req[gi] |=> flag[gi]);
    assert_flag_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[gi] && !sel_f) |=> flag[gi]);
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        flag,
  input  logic [NUM_SRC-1:0]        enable,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [LVL_W-1:0]          cur_lvl,
  output logic                      found,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [NUM_SRC-1:0] qual;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_qual
    assign qual[gi] = flag[gi] && enable[gi] &&
                      (LVL_W'(prio[gi*PRIO_W +: PRIO_W]) > cur_lvl);
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assert_grant_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> qual[win_idx]);
  assert_no_grant_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (qual == '0));
  assert_grant_above_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (LVL_W'(win_prio) > cur_lvl));
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack
  import intc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [PRIO_W-1:0] sw_bits,
  input  logic              push,
  input  logic              pop,
  input  logic [LVL_W-1:0]  new_lvl,
  output logic [LVL_W-1:0]  cur_lvl
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] cur_q, cur_d;
  logic [SP_W-1:0]  sp_q, sp_d;
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] stk_d [DEPTH];

  always_comb begin
    cur_d = cur_q;
    sp_d  = sp_q;
    stk_d = stk_q;
    if (pop && (sp_q != '0)) begin
      cur_d = stk_q[int'(sp_q) - 1];
      sp_d  = sp_q - 1'b1;
    end else if (push) begin
      cur_d = new_lvl;
      if (int'(sp_q) < DEPTH) begin
        stk_d[int'(sp_q)] = cur_q;
        sp_d              = sp_q + 1'b1;
      end
    end else if (sw_wr) begin
      cur_d = {cur_q[LVL_W-1], sw_bits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      cur_q <= cur_d;
      sp_q  <= sp_d;
      stk_q <= stk_d;
    end
  end

  assign cur_lvl = cur_q;

  assert_sw_keeps_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !push && !pop) |=> (cur_lvl[LVL_W-1] == $past(cur_lvl[LVL_W-1])));
  assert_push_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cur_lvl == $past(new_lvl)));
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (sp_q == '0) && !push && !sw_wr) |=> $stable(cur_lvl));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               cpu_ack,
  input  logic               cpu_ret,
  output logic               irq_out,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [LVL_W-1:0]   irq_lvl
);
  localparam int NFR         = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int NPR         = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int STACK_DEPTH = 1 << PRIO_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NUM_SRC-1:0]        flag, enable;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [LVL_W-1:0]          cur_lvl;
  logic                      found;
  logic [IDX_W-1:0]          win_idx;
  logic [PRIO_W-1:0]         win_prio;
  logic                      nest_q, nest_d;
  grant_t                    stat_q, stat_d;
  logic                      ack_take, lvl_wr;
  logic [LVL_W-1:0]          ack_lvl;
  int                        ai;

  assign ai = int'(bus_addr);

  intc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .hw_req    (irq_src),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flag      (flag),
    .enable    (enable),
    .prio      (prio)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flag     (flag),
    .enable   (enable),
    .prio     (prio),
    .cur_lvl  (cur_lvl),
    .found    (found),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  assign ack_take = cpu_ack && stat_q.valid && !cpu_ret;
  assign lvl_wr   = bus_wr && (ai == A_LEVEL);
  assign ack_lvl  = nest_q ? TOP_USER_LVL : stat_q.lvl;

  intc_lvl_stack #(.DEPTH(STACK_DEPTH)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sw_wr   (lvl_wr),
    .sw_bits (bus_wdata[PRIO_W-1:0]),
    .push    (ack_take),
    .pop     (cpu_ret),
    .new_lvl (ack_lvl),
    .cur_lvl (cur_lvl)
  );

  // control and status next state
  always_comb begin
    nest_d = nest_q;
    if (bus_wr && (ai == A_CTRL)) nest_d = bus_wdata[0];
  end

  always_comb begin
    stat_d.valid = found;
    stat_d.vec   = found ? (VEC_W'(win_idx) + VEC_W'(VEC_BASE)) : '0;
    stat_d.lvl   = found ? LVL_W'(win_prio) : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      nest_q <= 1'b0;
      stat_q <= '0;
    end else begin
      nest_q <= nest_d;
      stat_q <= stat_d;
    end
  end

  assign irq_out = stat_q.valid;
  assign irq_vec = stat_q.vec;
  assign irq_lvl = stat_q.lvl;

  // read path, register words padded to the bus width
  logic [NFR*DATA_W-1:0] flag_pad, en_pad;
  logic [NPR*DATA_W-1:0] prio_pad;

  always_comb begin
    flag_pad = '0;
    en_pad   = '0;
    prio_pad = '0;
    flag_pad[NUM_SRC-1:0] = flag;
    en_pad[NUM_SRC-1:0]   = enable;
    for (int j = 0; j < NUM_SRC; j++) begin
      prio_pad[(j / FIELDS_PER_REG) * DATA_W + (j % FIELDS_PER_REG) * PRIO_W +: PRIO_W] =
        prio[j*PRIO_W +: PRIO_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ai == A_CTRL) begin
      bus_rdata[0] = nest_q;
    end else if (ai == A_LEVEL) begin
      bus_rdata[LVL_W-1:0] = cur_lvl;
    end else if (ai == A_STATUS) begin
      bus_rdata[VEC_W-1:0]   = stat_q.vec;
      bus_rdata[8 +: LVL_W]  = stat_q.lvl;
    end else if ((ai >= A_FLAG) && (ai < A_FLAG + NFR)) begin
      bus_rdata = flag_pad[(ai - A_FLAG) * DATA_W +: DATA_W];
    end else if ((ai >= A_ENABLE) && (ai < A_ENABLE + NFR)) begin
      bus_rdata = en_pad[(ai - A_ENABLE) * DATA_W +: DATA_W];
    end else if ((ai >= A_PRIO) && (ai < A_PRIO + NPR)) begin
      bus_rdata = prio_pad[(ai - A_PRIO) * DATA_W +: DATA_W];
    end
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !irq_out |-> ((irq_vec == '0) && (irq_lvl == '0)));
  assert_vec_span_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_out |-> ((irq_vec >= VEC_BASE) && (irq_vec < VEC_BASE + NUM_SRC) && (irq_lvl != '0)));
  assert_nest_cap_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ack_take && nest_q) |=> (cur_lvl == TOP_USER_LVL));
endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] irq_src;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        cpu_ack, cpu_ret;
  logic        irq_out;
  logic [6:0]  irq_vec;
  logic [3:0]  irq_lvl;

  int checks = 0;
  int errors = 0;

  // reference state kept by the bench
  int          m_prio [N];
  logic [7:0]  m_en, m_flag;
  int          m_lvl;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  prio_vec_intc #(.NUM_SRC(N)) u_prio_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .irq_out(irq_out),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); cpu_ret = 1'b1;
    @(negedge clk); cpu_ret = 1'b0;
  endtask

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic logic [15:0] exp_stat();
    int best = 0;
    int bi = -1;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_en[i] && (m_prio[i] > m_lvl) && (m_prio[i] > best)) begin
        best = m_prio[i];
        bi   = i;
      end
    if (bi < 0) return 16'h0000;
    return 16'((best << 8) | (bi + 8));
  endfunction

  function automatic logic [15:0] pack_prio(input int r);
    logic [15:0] v = '0;
    for (int j = 0; j < 4; j++) v[j*3 +: 3] = 3'(m_prio[r*4 + j]);
    return v;
  endfunction

  task automatic apply_model();
    wr(6'h20, pack_prio(0));
    wr(6'h21, pack_prio(1));
    wr(6'h10, {8'h00, m_en});
    wr(6'h08, {8'h00, m_flag});
    wr(6'h01, 16'(m_lvl));
    settle();
  endtask

  task automatic check_status(input string req);
    logic [15:0] s, e;
    e = exp_stat();
    rd(6'h02, s);
    chk(req, "status word", s, e);
    chk(req, "irq_out/irq_vec/irq_lvl", {3'b0, irq_out, irq_lvl, 1'b0, irq_vec},
        {3'b0, (e != 0), e[11:8], 1'b0, e[6:0]});
  endtask

  task automatic clear_model();
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    m_en = '0; m_flag = '0; m_lvl = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; irq_src = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cpu_ack = 1'b0; cpu_ret = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset contents and unmapped reads
    foreach (d[i]) ;
    for (int k = 0; k < 9; k++) begin
      logic [5:0] a;
      case (k)
        0: a = 6'h00; 1: a = 6'h01; 2: a = 6'h02; 3: a = 6'h08; 4: a = 6'h10;
        5: a = 6'h20; 6: a = 6'h21; 7: a = 6'h05; default: a = 6'h3F;
      endcase
      rd(a, d);
      chk("R11", "reset/unmapped read", d, 16'h0000);
    end
    chk("R11", "irq_out after reset", {15'b0, irq_out}, 16'h0000);

    // R4: priority packing and unused top bits
    wr(6'h20, 16'hFFFF); rd(6'h20, d); chk("R4", "prio word 0 readback", d, 16'h0FFF);
    wr(6'h21, 16'hABCD); rd(6'h21, d); chk("R4", "prio word 1 readback", d, 16'h0BCD);
    wr(6'h21, 16'h0000);

    // R1/R3: hardware latch while disabled
    @(negedge clk); irq_src = 8'h05;
    @(negedge clk); irq_src = 8'h00;
    rd(6'h08, d); chk("R1", "flags after pulse", d, 16'h0005);
    settle();
    chk("R3", "disabled sources give no irq", {15'b0, irq_out}, 16'h0000);
    repeat (3) @(negedge clk);
    rd(6'h08, d); chk("R1", "flags held", d, 16'h0005);
    wr(6'h10, 16'h0004); settle();
    rd(6'h02, d); chk("R3", "only enabled source 2 wins", d, 16'h070A);

    // R2: software set, and hardware set beats clearing write
    wr(6'h08, 16'h00FF); rd(6'h08, d); chk("R2", "software set", d, 16'h00FF);
    @(negedge clk); bus_addr = 6'h08; bus_wdata = 16'h0000; bus_wr = 1'b1; irq_src = 8'h08;
    @(negedge clk); bus_wr = 1'b0; irq_src = 8'h00;
    rd(6'h08, d); chk("R2", "clear races hardware set", d, 16'h0008);

    // R8: top level bit not writable
    wr(6'h01, 16'h000F); rd(6'h01, d); chk("R8", "level write masks bit 3", d, 16'h0007);
    wr(6'h01, 16'h0000); rd(6'h01, d); chk("R8", "level write zero", d, 16'h0000);

    // R7/R6: status read-only, strict compare, priority 0
    clear_model();
    m_prio[1] = 4; m_en = 8'h02; m_flag = 8'h02;
    apply_model(); check_status("R7");
    wr(6'h02, 16'hFFFF); settle();
    rd(6'h02, d); chk("R7", "status ignores write", d, 16'h0409);
    m_lvl = 4; apply_model(); check_status("R6");
    m_lvl = 3; apply_model(); check_status("R6");
    m_lvl = 0; m_prio[1] = 0; apply_model(); check_status("R4");

    // R5: equal priorities pick lowest index
    for (int i = 0; i < N; i++) m_prio[i] = 5;
    m_en = 8'hFF; m_flag = 8'hFF; apply_model(); check_status("R5");
    m_en = 8'hFE; apply_model(); check_status("R5");
    m_flag = 8'hC0; apply_model(); check_status("R5");

    // R5/R6: sweep of patterns against every CPU level
    for (int t = 0; t < 96; t++) begin
      for (int i = 0; i < N; i++)
        m_prio[i] = (t % 2 == 1) ? int'(nxt() % 2) + 5 : int'(nxt() % 8);
      m_en   = 8'(nxt());
      m_flag = 8'(nxt());
      m_lvl  = t % 8;
      apply_model();
      check_status((t % 2 == 1) ? "R5" : "R6");
    end

    // R9/R10: acknowledge, nest, return
    clear_model();
    m_prio[2] = 3; m_prio[5] = 6; m_en = 8'h24; m_flag = 8'h24;
    apply_model(); check_status("R9");
    pulse_ack(); rd(6'h01, d); chk("R9", "ack loads level", d, 16'h0006);
    settle(); chk("R6", "irq drops at raised level", {15'b0, irq_out}, 16'h0000);
    m_prio[2] = 7; m_lvl = 6; apply_model(); check_status("R5");
    pulse_ack(); rd(6'h01, d); chk("R9", "nested ack loads level", d, 16'h0007);
    pulse_ret(); rd(6'h01, d); chk("R10", "first return", d, 16'h0006);
    settle(); m_lvl = 6; check_status("R10");
    pulse_ret(); rd(6'h01, d); chk("R10", "second return", d, 16'h0000);
    pulse_ret(); rd(6'h01, d); chk("R10", "return on empty stack", d, 16'h0000);

    m_flag = 8'h00; m_lvl = 0; apply_model();
    chk("R9", "irq low before ignored ack", {15'b0, irq_out}, 16'h0000);
    pulse_ack(); rd(6'h01, d); chk("R9", "ack while idle ignored", d, 16'h0000);

    // R9: nesting disabled blocks preemption
    wr(6'h00, 16'h0001); rd(6'h00, d); chk("R9", "nest-disable readback", d, 16'h0001);
    m_prio[2] = 3; m_prio[5] = 0; m_flag = 8'h04; apply_model(); check_status("R9");
    pulse_ack(); rd(6'h01, d); chk("R9", "nest-disable loads top level", d, 16'h0007);
    wr(6'h21, 16'h0038); wr(6'h08, 16'h0024); settle();
    chk("R9", "no preemption when nesting off", {15'b0, irq_out}, 16'h0000);
    pulse_ret(); rd(6'h01, d); chk("R10", "return after nest-off ack", d, 16'h0000);
    settle(); rd(6'h02, d); chk("R5", "top source presented after return", d, 16'h070D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule